// File: doc/BRIEF.md
# Interrupt-to-DMA Activation Router

This block sits between a handful of peripheral interrupt lines and two consumers: the CPU interrupt input and a multi-channel DMA engine. A request flag for each source is set when the source line rises. A 2-bit route code for each source then decides where the pending request goes. It can go to the CPU only, to DMA only, or to DMA followed by a CPU interrupt. In the third case the route code rewrites itself back to CPU-only when it fires.

Each source carries a channel mask and a transfer-form code. When a DMA route fires, every channel in the mask gets a one-cycle activation pulse. Each channel answers with a done strobe per operand and marks its final operand with a last strobe. The transfer form and the number of mapped channels decide when the request flag is cleared. A single-channel transfer in single-operand or nonstop form clears the flag when it is activated. A consecutive-operand transfer, or any transfer spread over more than one channel, clears the flag on each individual done strobe instead. Software programs the route code, form, mask and flag through a one-cycle register write port.

Top module: `irq_dma_router`

## Requirements
- R1: After reset every flag, route code and channel mask is zero, and `cpu_irq` and `dma_act` are low.
- R2: A rising edge on `src_irq[s]` sets flag `s` one clock later. A level that stays high does not set the flag again. A rising edge wins over a software clear in the same cycle.
- R3: `cpu_irq[s]` is high exactly while flag `s` is set and its route code is 00. Writing register 3 (flag) with data bit 0 equal to 0 clears the flag. Writing it with bit 0 equal to 1 has no effect.
- R4: With route code 01, a set flag on an idle source with a nonzero mask produces a pulse of exactly one cycle on the masked bits of `dma_act`, one clock after the flag is seen. `cpu_irq` stays low.
- R5: With form code 00 (single) or 01 (nonstop) and exactly one channel in the mask, route 01 clears the flag at the edge that issues the activation.
- R6: With form code 10 or 11 (consecutive), route 01 leaves the flag set at activation and clears it on each done strobe from a channel of the running transfer. A new edge during the transfer sets the flag again, and the next done strobe clears it.
- R7: With two or more channels in the mask, all of them pulse in the same cycle whatever the form. The flag is cleared on each channel's done strobe.
- R8: With route code 11, activation rewrites the route code to 00 at the same edge. The flag stays set, so `cpu_irq` rises together with the rewrite.
- R9: If software writes route code 11 while a consecutive or multi-channel transfer is running, the next done strobe of that transfer returns the code to 00 and leaves the flag set.
- R10: A source does not activate again while its transfer is running. A transfer ends on each channel at a done strobe for single and nonstop forms, and at done together with last for consecutive form. A pending flag activates one clock after the end.
- R11: Register writes use `wr_reg` 0 for the route code (data bits 1:0), 1 for the form code (bits 1:0), 2 for the channel mask and 3 for the flag. A route-code write takes priority over the automatic rewrite in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_irq | input | N_SRC | Peripheral interrupt lines, edge-detected |
| wr_en | input | 1 | Register write strobe |
| wr_src | input | SW | Source index of the write |
| wr_reg | input | 2 | Register select: 0 route, 1 form, 2 mask, 3 flag |
| wr_data | input | N_CH | Write data |
| dma_done | input | N_CH | Per-channel operand-done strobe |
| dma_last | input | N_CH | Per-channel final-operand marker, qualified by dma_done |
| cpu_irq | output | N_SRC | Registered CPU interrupt request per source |
| dma_act | output | N_CH | Registered one-cycle channel activation pulses |
| flag_o | output | N_SRC | Request flag state per source |
| sel_o | output | 2*N_SRC | Route code per source, source s at bits 2s+1:2s |

## Verification
A rising source line shows up in `flag_o` after one edge. The activation pulse on `dma_act` comes one edge after that. The flag clear or route rewrite that belongs to an activation is visible at the same edge as the pulse. A done strobe clears the flag, rewrites the route code or ends the transfer at the edge that samples it, and any re-activation follows one edge later. The bench drives every input 1 ns after a rising edge and reads the outputs at that same moment after each edge. Each check is therefore placed at the exact edge count worked out above, and the cycles where a pulse must be absent are checked along with those where it must appear.

// File: rtl/irq_dma_pkg.sv
package irq_dma_pkg;
  // route codes
  localparam logic [1:0] RT_CPU     = 2'b00;
  localparam logic [1:0] RT_DMA     = 2'b01;
  localparam logic [1:0] RT_DMA_CPU = 2'b11;
  // register selects
  localparam logic [1:0] REG_ROUTE = 2'd0;
  localparam logic [1:0] REG_FORM  = 2'd1;
  localparam logic [1:0] REG_MASK  = 2'd2;
  localparam logic [1:0] REG_FLAG  = 2'd3;

  typedef enum logic [1:0] {
    FORM_SINGLE  = 2'b00,
    FORM_NONSTOP = 2'b01,
    FORM_CONSEC  = 2'b10,
    FORM_CONSEC3 = 2'b11
  } xfer_form_e;
endpackage

// File: rtl/irq_src_ctrl.sv
module irq_src_ctrl
  import irq_dma_pkg::*;
#(
  parameter int N_CH = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            src_in,
  input  logic            wr_hit,
  input  logic [1:0]      wr_reg,
  input  logic [N_CH-1:0] wr_data,
  input  logic [N_CH-1:0] dma_done,
  input  logic [N_CH-1:0] dma_last,
  output logic            act_o,
  output logic [N_CH-1:0] mask_o,
  output logic            flag_o,
  output logic [1:0]      route_o,
  output logic            irq_o
);
  logic            prev_q;
  logic            flag_q, flag_d;
  logic [1:0]      route_q, route_d;
  xfer_form_e      form_q;
  logic [N_CH-1:0] mask_q;
  logic [N_CH-1:0] busy_q, busy_d;
  logic            irq_q;

  logic            rise, multi, per_xfer, idle, hit, act;
  logic            clr_hw, clr_sw, wr_route;
  logic [N_CH-1:0] end_mask;

  always_comb begin
    rise     = src_in & ~prev_q;
    multi    = ($countones(mask_q) > 1);
    per_xfer = form_q[1] | multi;
    idle     = (busy_q == '0);
    hit      = |(dma_done & busy_q);
    act      = flag_q & route_q[0] & idle & (mask_q != '0);
    end_mask = form_q[1] ? (dma_done & dma_last) : dma_done;
    busy_d   = act ? mask_q : (busy_q & ~end_mask);

    clr_hw   = (route_q == RT_DMA) & (per_xfer ? hit : act);
    clr_sw   = wr_hit & (wr_reg == REG_FLAG) & ~wr_data[0];
    flag_d   = rise | (flag_q & ~(clr_hw | clr_sw));

    wr_route = wr_hit & (wr_reg == REG_ROUTE);
    if (wr_route)
      route_d = wr_data[1:0];
    else if (route_q == RT_DMA_CPU && (act || (per_xfer && hit)))
      route_d = RT_CPU;
    else
      route_d = route_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q  <= 1'b0;
      flag_q  <= 1'b0;
      route_q <= RT_CPU;
      form_q  <= FORM_SINGLE;
      mask_q  <= '0;
      busy_q  <= '0;
      irq_q   <= 1'b0;
    end else begin
      prev_q  <= src_in;
      flag_q  <= flag_d;
      route_q <= route_d;
      busy_q  <= busy_d;
      irq_q   <= flag_d & (route_d == RT_CPU);
      if (wr_hit && wr_reg == REG_FORM) form_q <= xfer_form_e'(wr_data[1:0]);
      if (wr_hit && wr_reg == REG_MASK) mask_q <= wr_data;
    end
  end

  assign act_o   = act;
  assign mask_o  = mask_q;
  assign flag_o  = flag_q;
  assign route_o = route_q;
  assign irq_o   = irq_q;
endmodule

// File: rtl/dma_act_merge.sv
module dma_act_merge #(
  parameter int N_SRC = 4,
  parameter int N_CH  = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [N_SRC-1:0]      act,
  input  logic [N_SRC*N_CH-1:0] masks,
  output logic [N_CH-1:0]       dma_act
);
  logic [N_CH-1:0] merged;

  always_comb begin
    merged = '0;
    for (int s = 0; s < N_SRC; s++)
      if (act[s]) merged = merged | masks[s*N_CH +: N_CH];
  end

  always_ff @(posedge clk) begin
    if (rst) dma_act <= '0;
    else     dma_act <= merged;
  end
endmodule

// File: rtl/irq_dma_router.sv
module irq_dma_router
  import irq_dma_pkg::*;
#(
  parameter int N_SRC = 4,
  parameter int N_CH  = 4,
  localparam int SW   = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_SRC-1:0]   src_irq,
  input  logic               wr_en,
  input  logic [SW-1:0]      wr_src,
  input  logic [1:0]         wr_reg,
  input  logic [N_CH-1:0]    wr_data,
  input  logic [N_CH-1:0]    dma_done,
  input  logic [N_CH-1:0]    dma_last,
  output logic [N_SRC-1:0]   cpu_irq,
  output logic [N_CH-1:0]    dma_act,
  output logic [N_SRC-1:0]   flag_o,
  output logic [2*N_SRC-1:0] sel_o
);
  logic [N_SRC-1:0]      act;
  logic [N_SRC*N_CH-1:0] masks;
  logic [N_CH-1:0]       mask_union;

  for (genvar s = 0; s < N_SRC; s++) begin : g_src
    logic wr_hit;
    assign wr_hit = wr_en & (wr_src == SW'(s));
    irq_src_ctrl #(.N_CH(N_CH)) u_src (
      .clk      (clk),
      .rst      (rst),
      .src_in   (src_irq[s]),
      .wr_hit   (wr_hit),
      .wr_reg   (wr_reg),
      .wr_data  (wr_data),
      .dma_done (dma_done),
      .dma_last (dma_last),
      .act_o    (act[s]),
      .mask_o   (masks[s*N_CH +: N_CH]),
      .flag_o   (flag_o[s]),
      .route_o  (sel_o[2*s +: 2]),
      .irq_o    (cpu_irq[s])
    );
  end

  always_comb begin
    mask_union = '0;
    for (int s = 0; s < N_SRC; s++) mask_union = mask_union | masks[s*N_CH +: N_CH];
  end

  dma_act_merge #(.N_SRC(N_SRC), .N_CH(N_CH)) u_merge (
    .clk     (clk),
    .rst     (rst),
    .act     (act),
    .masks   (masks),
    .dma_act (dma_act)
  );
endmodule

// File: rtl/irq_dma_router_chk.sv
module irq_dma_router_chk #(
  parameter int N_SRC = 4,
  parameter int N_CH  = 4
) (
  input logic               clk,
  input logic               rst,
  input logic [N_SRC-1:0]   src_irq,
  input logic [N_SRC-1:0]   cpu_irq,
  input logic [N_CH-1:0]    dma_act,
  input logic [N_SRC-1:0]   flag_o,
  input logic [2*N_SRC-1:0] sel_o,
  input logic [N_CH-1:0]    mask_union
);
  for (genvar s = 0; s < N_SRC; s++) begin : g_chk
    // R2: a rising line is latched by the next edge
    a_r2_rise_sets: assert property (@(posedge clk) disable iff (rst)
      $rose(src_irq[s]) |=> flag_o[s]);
    // R3: CPU request only with a set flag and route 00
    a_r3_irq_needs_flag: assert property (@(posedge clk) disable iff (rst)
      cpu_irq[s] |-> (flag_o[s] && sel_o[2*s +: 2] == 2'b00));
  end

  // R4: activation pulses last one cycle
  a_r4_single_pulse: assert property (@(posedge clk) disable iff (rst)
    (dma_act != '0) |=> ((dma_act & $past(dma_act)) == '0));

  // R4: only channels that some source maps may pulse
  a_r4_masked_only: assert property (@(posedge clk) disable iff (rst)
    (dma_act & ~$past(mask_union)) == '0);
endmodule

bind irq_dma_router irq_dma_router_chk #(.N_SRC(N_SRC), .N_CH(N_CH)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .src_irq    (src_irq),
  .cpu_irq    (cpu_irq),
  .dma_act    (dma_act),
  .flag_o     (flag_o),
  .sel_o      (sel_o),
  .mask_union (mask_union)
);

// File: tb/irq_dma_router_tb.sv
`timescale 1ns/1ps
module irq_dma_router_tb;
  localparam int N_SRC = 4;
  localparam int N_CH  = 4;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [N_SRC-1:0] src_irq = '0;
  logic             wr_en = 1'b0;
  logic [1:0]       wr_src = '0;
  logic [1:0]       wr_reg = '0;
  logic [N_CH-1:0]  wr_data = '0;
  logic [N_CH-1:0]  dma_done = '0;
  logic [N_CH-1:0]  dma_last = '0;
  logic [N_SRC-1:0] cpu_irq;
  logic [N_CH-1:0]  dma_act;
  logic [N_SRC-1:0] flag_o;
  logic [2*N_SRC-1:0] sel_o;

  int checks = 0;
  int errs   = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  irq_dma_router #(.N_SRC(N_SRC), .N_CH(N_CH)) u_dut (
    .clk(clk), .rst(rst), .src_irq(src_irq), .wr_en(wr_en), .wr_src(wr_src),
    .wr_reg(wr_reg), .wr_data(wr_data), .dma_done(dma_done), .dma_last(dma_last),
    .cpu_irq(cpu_irq), .dma_act(dma_act), .flag_o(flag_o), .sel_o(sel_o)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(int s, int r, logic [N_CH-1:0] d);
    wr_en = 1'b1; wr_src = 2'(s); wr_reg = 2'(r); wr_data = d;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic done_pulse(logic [N_CH-1:0] d, logic [N_CH-1:0] l);
    dma_done = d; dma_last = l;
    tick();
    dma_done = '0; dma_last = '0;
  endtask

  task automatic t_reset();
    chk("R1 flags", 32'(flag_o), 0);
    chk("R1 route", 32'(sel_o), 0);
    chk("R1 cpu_irq", 32'(cpu_irq), 0);
    chk("R1 dma_act", 32'(dma_act), 0);
  endtask

  task automatic t_cpu_route();
    src_irq[0] = 1'b1; tick();
    chk("R2 flag set", 32'(flag_o[0]), 1);
    chk("R3 cpu_irq", 32'(cpu_irq[0]), 1);
    tick();
    chk("R3 no dma", 32'(dma_act), 0);
    wr(0, 3, 4'b0001);
    chk("R3 write-one ignored", 32'(flag_o[0]), 1);
    wr(0, 3, 4'b0000);
    chk("R3 sw clear", 32'(flag_o[0]), 0);
    chk("R3 cpu_irq drop", 32'(cpu_irq[0]), 0);
    tick();
    chk("R2 held level", 32'(flag_o[0]), 0);
    src_irq[0] = 1'b0; tick();
    src_irq[0] = 1'b1;
    wr(0, 3, 4'b0000);
    chk("R2 set wins", 32'(flag_o[0]), 1);
    wr(0, 3, 4'b0000);
    src_irq[0] = 1'b0; tick();
  endtask

  task automatic t_single_chan();
    wr(1, 2, 4'b0001); wr(1, 1, 4'b0001); wr(1, 0, 4'b0001);
    src_irq[1] = 1'b1; tick();
    chk("R4 flag", 32'(flag_o[1]), 1);
    chk("R4 not yet", 32'(dma_act), 0);
    tick();
    chk("R4 pulse", 32'(dma_act), 4'b0001);
    chk("R5 cleared at act", 32'(flag_o[1]), 0);
    chk("R4 no cpu", 32'(cpu_irq[1]), 0);
    tick();
    chk("R4 one cycle", 32'(dma_act), 0);
    src_irq[1] = 1'b0; tick();
    src_irq[1] = 1'b1; tick();
    chk("R10 pending", 32'(flag_o[1]), 1);
    tick();
    chk("R10 no act busy", 32'(dma_act), 0);
    src_irq[1] = 1'b0;
    done_pulse(4'b0001, 4'b0000);
    chk("R10 end edge", 32'(dma_act), 0);
    tick();
    chk("R10 reactivate", 32'(dma_act), 4'b0001);
    chk("R5 cleared again", 32'(flag_o[1]), 0);
    done_pulse(4'b0001, 4'b0000);
  endtask

  task automatic t_consec();
    wr(2, 2, 4'b0010); wr(2, 1, 4'b0010); wr(2, 0, 4'b0001);
    src_irq[2] = 1'b1; tick(); tick();
    chk("R6 pulse", 32'(dma_act), 4'b0010);
    chk("R6 kept at act", 32'(flag_o[2]), 1);
    src_irq[2] = 1'b0;
    done_pulse(4'b0010, 4'b0000);
    chk("R6 clr op1", 32'(flag_o[2]), 0);
    src_irq[2] = 1'b1; tick();
    chk("R6 re-set", 32'(flag_o[2]), 1);
    tick();
    chk("R10 busy consec", 32'(dma_act), 0);
    src_irq[2] = 1'b0;
    done_pulse(4'b0010, 4'b0000);
    chk("R6 clr op2", 32'(flag_o[2]), 0);
    done_pulse(4'b0010, 4'b0010);
    tick();
    chk("R6 idle", 32'(dma_act), 0);
  endtask

  task automatic t_multi();
    wr(3, 2, 4'b1100); wr(3, 1, 4'b0000); wr(3, 0, 4'b0001);
    src_irq[3] = 1'b1; tick(); tick();
    chk("R7 both pulse", 32'(dma_act), 4'b1100);
    chk("R7 kept at act", 32'(flag_o[3]), 1);
    src_irq[3] = 1'b0;
    done_pulse(4'b0100, 4'b0000);
    chk("R7 clr ch2", 32'(flag_o[3]), 0);
    src_irq[3] = 1'b1; tick();
    src_irq[3] = 1'b0;
    done_pulse(4'b1000, 4'b0000);
    chk("R7 clr ch3", 32'(flag_o[3]), 0);
    tick();
    chk("R7 idle", 32'(dma_act), 0);
  endtask

  task automatic t_oneshot();
    wr(1, 0, 4'b0011);
    chk("R11 route write", 32'(sel_o[3:2]), 3);
    src_irq[1] = 1'b1; tick();
    chk("R8 no cpu before", 32'(cpu_irq[1]), 0);
    tick();
    chk("R8 pulse", 32'(dma_act), 4'b0001);
    chk("R8 route to 00", 32'(sel_o[3:2]), 0);
    chk("R8 flag kept", 32'(flag_o[1]), 1);
    chk("R8 cpu_irq", 32'(cpu_irq[1]), 1);
    src_irq[1] = 1'b0;
    done_pulse(4'b0001, 4'b0000);
    wr(1, 3, 4'b0000);
  endtask

  task automatic t_rearm();
    wr(2, 0, 4'b0011);
    src_irq[2] = 1'b1; tick(); tick();
    chk("R9 pulse", 32'(dma_act), 4'b0010);
    chk("R9 first rewrite", 32'(sel_o[5:4]), 0);
    src_irq[2] = 1'b0;
    wr(2, 0, 4'b0011);
    chk("R11 rewrite wins", 32'(sel_o[5:4]), 3);
    done_pulse(4'b0010, 4'b0000);
    chk("R9 back to 00", 32'(sel_o[5:4]), 0);
    chk("R9 flag kept", 32'(flag_o[2]), 1);
    done_pulse(4'b0010, 4'b0010);
    tick();
    chk("R9 no act on 00", 32'(dma_act), 0);
    wr(2, 3, 4'b0000);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    t_reset();
    t_cpu_route();
    t_single_chan();
    t_consec();
    t_multi();
    t_oneshot();
    t_rearm();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errs++; checks++;
      $display("FAIL R1 watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule